// File: doc/BRIEF.md
# Windowed Return Legality Checker

This block judges a windowed return in a register-window machine before the window is rotated. It takes the two-bit call-size tag held in the top of the return-address register, the current window base and the window-start bitmap. From these it decides whether the return is illegal, whether it must trap as a window underflow, or whether it is a plain return. For a legal return it produces the rotated window base. For an underflow it also reports the 4-, 8- or 12-register trap variant, sets the exception-mode flag and saves the base in force before the trap together with the faulting PC.

The same backward probe of the bitmap serves a stack-pointer-move check. That check raises an alloca flag when none of the three windows just below the current base is marked as started. Every bitmap index wraps modulo the window count NAREG/4. All results are registered and appear one clock after the request strobe. Filling registers from memory belongs to the trap handler and is not part of this block.

Top module: `wrc_top`

## Requirements
- R1: The call size n is the `link_tag` input (bits 31:30 of the return-address register). A return with n = 0 is illegal.
- R2: The probe value m is 1, 2 or 3 for the first set bitmap bit found at base-1, then base-2, then base-3. m is 0 when all three are clear. The search stops at the first hit.
- R3: A return is illegal when m is nonzero and differs from n.
- R4: A legal return whose bitmap bit at base-n is clear is an underflow. `uf_code` then equals n (1 = 4-register, 2 = 8-register, 3 = 12-register variant), `excm` is 1, `old_base` loads the base in force and `fault_pc` loads `pc`.
- R5: A legal return whose bitmap bit at base-n is set is a normal return. `uf_code` is 0 (none) and `excm` is 0.
- R6: On every legal return, `new_base` becomes base-n modulo NAREG/4. This holds for both normal returns and underflows.
- R7: The illegal check has priority. An illegal return gives `uf_code` 0 and `excm` 0, and `new_base` loads the unchanged base. `old_base` and `fault_pc` keep their previous values.
- R8: All bitmap indices wrap modulo NAREG/4. A base near 0 therefore probes the bits at the top of the bitmap.
- R9: A stack-pointer-move request (`movsp_valid`) sets `alloca` one cycle later if and only if the bits at base-1, base-2 and base-3 are all clear.
- R10: Results appear one cycle after `ret_valid`, with `ret_done` high. In any cycle without `ret_done`, `illegal`, `uf_code` and `excm` are 0. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | Windowed return request |
| link_tag | input | 2 | Call size, bits 31:30 of the return-address register |
| pc | input | PC_W | PC of the return instruction |
| movsp_valid | input | 1 | Stack-pointer-move request |
| win_base | input | WBW | Current window base |
| win_start | input | NW | Window-start bitmap |
| ret_done | output | 1 | Return result valid |
| illegal | output | 1 | Illegal-instruction flag |
| uf_code | output | 2 | Underflow variant: 0 none, 1/2/3 for 4/8/12 registers |
| excm | output | 1 | Exception mode set by an underflow |
| old_base | output | WBW | Base saved on underflow |
| new_base | output | WBW | Window base after the return |
| fault_pc | output | PC_W | PC saved on underflow |
| alloca | output | 1 | Alloca condition for stack-pointer move |

## Verification
The bench builds the block with NAREG = 16, which gives four windows and a two-bit base. At that size, base-3 lands on base+1 and the probe crosses the bitmap edge from almost every base. This exercises the modulo wrap, and the interaction between search order and size mismatch, with a handful of bitmap values. A ring that small also means a return of size 3 from base 0 reads bit 1. So wrap mistakes show up directly in `new_base` and in the underflow decision.

// File: rtl/wrc_pkg.sv
package wrc_pkg;

  typedef enum logic [1:0] {
    UF_NONE = 2'd0,
    UF_4    = 2'd1,
    UF_8    = 2'd2,
    UF_12   = 2'd3
  } uf_code_t;

  // Backward step through the window ring; nw is a power of two.
  function automatic int win_back(input int base, input int k, input int nw);
    return (base - k) & (nw - 1);
  endfunction

  // First started window among the three below the base, 0 if none.
  function automatic logic [1:0] first_hit(input logic [3:1] seen);
    if (seen[1])      return 2'd1;
    else if (seen[2]) return 2'd2;
    else if (seen[3]) return 2'd3;
    else              return 2'd0;
  endfunction

endpackage

// File: rtl/wrc_probe.sv
module wrc_probe #(
  parameter int NW  = 16,
  parameter int WBW = 4
) (
  input  logic [WBW-1:0] win_base,
  input  logic [NW-1:0]  win_start,
  output logic [3:1]     seen,
  output logic [1:0]     m_sel
);
  import wrc_pkg::*;

  for (genvar k = 1; k <= 3; k++) begin : g_tap
    logic [WBW-1:0] idx;
    assign idx     = WBW'(win_back(int'(win_base), k, NW));
    assign seen[k] = win_start[idx];
  end

  assign m_sel = first_hit(seen);
endmodule

// File: rtl/wrc_classify.sv
module wrc_classify (
  input  logic [1:0]        n_size,
  input  logic [1:0]        m_sel,
  input  logic [3:1]        seen,
  output logic              ill,
  output logic              uf,
  output wrc_pkg::uf_code_t code
);
  import wrc_pkg::*;

  logic bit_at_n;

  always_comb begin
    unique case (n_size)
      2'd1:    bit_at_n = seen[1];
      2'd2:    bit_at_n = seen[2];
      2'd3:    bit_at_n = seen[3];
      default: bit_at_n = 1'b1;
    endcase
  end

  assign ill  = (n_size == 2'd0) || ((m_sel != 2'd0) && (m_sel != n_size));
  assign uf   = !ill && !bit_at_n;
  assign code = uf ? uf_code_t'(n_size) : UF_NONE;
endmodule

// File: rtl/wrc_top.sv
module wrc_top #(
  parameter int NAREG = 64,
  parameter int PC_W  = 32,
  localparam int NW   = NAREG / 4,
  localparam int WBW  = $clog2(NW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ret_valid,
  input  logic [1:0]      link_tag,
  input  logic [PC_W-1:0] pc,
  input  logic            movsp_valid,
  input  logic [WBW-1:0]  win_base,
  input  logic [NW-1:0]   win_start,
  output logic            ret_done,
  output logic            illegal,
  output logic [1:0]      uf_code,
  output logic            excm,
  output logic [WBW-1:0]  old_base,
  output logic [WBW-1:0]  new_base,
  output logic [PC_W-1:0] fault_pc,
  output logic            alloca
);
  import wrc_pkg::*;

  logic [3:1]     seen;
  logic [1:0]     m_sel;
  logic           ill_w;
  logic           uf_w;
  uf_code_t       code_w;
  logic [WBW-1:0] rot_base;
  logic           none_below;

  wrc_probe #(.NW(NW), .WBW(WBW)) probe_i (
    .win_base (win_base),
    .win_start(win_start),
    .seen     (seen),
    .m_sel    (m_sel)
  );

  wrc_classify class_i (
    .n_size(link_tag),
    .m_sel (m_sel),
    .seen  (seen),
    .ill   (ill_w),
    .uf    (uf_w),
    .code  (code_w)
  );

  assign rot_base   = WBW'(win_back(int'(win_base), int'(link_tag), NW));
  assign none_below = (seen == 3'b000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_done <= 1'b0;
      illegal  <= 1'b0;
      uf_code  <= UF_NONE;
      excm     <= 1'b0;
      old_base <= '0;
      new_base <= '0;
      fault_pc <= '0;
      alloca   <= 1'b0;
    end else begin
      ret_done <= ret_valid;
      illegal  <= ret_valid && ill_w;
      uf_code  <= ret_valid ? code_w : UF_NONE;
      excm     <= ret_valid && uf_w;
      alloca   <= movsp_valid && none_below;
      if (ret_valid) new_base <= ill_w ? win_base : rot_base;
      if (ret_valid && uf_w) begin
        old_base <= win_base;
        fault_pc <= pc;
      end
    end
  end
endmodule

// File: rtl/wrc_checker.sv
module wrc_checker #(
  parameter int WBW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ret_valid,
  input logic [1:0]     link_tag,
  input logic [WBW-1:0] win_base,
  input logic           ret_done,
  input logic           illegal,
  input logic [1:0]     uf_code,
  input logic           excm,
  input logic [WBW-1:0] old_base,
  input logic [WBW-1:0] new_base
);
  logic [WBW-1:0] q_base;
  logic [1:0]     q_n;

  always_ff @(posedge clk) begin
    q_base <= win_base;
    q_n    <= link_tag;
  end

  // R10
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> ret_done);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_done |-> (!illegal && uf_code == 2'd0 && !excm));

  // R1
  zero_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_done && q_n == 2'd0) |-> illegal);

  // R7
  illegal_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (uf_code == 2'd0 && !excm && new_base == q_base));

  // R4
  underflow_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_done && uf_code != 2'd0) |-> (excm && old_base == q_base && uf_code == q_n));

  // R6
  rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_done && !illegal) |-> (new_base == WBW'(q_base - WBW'(q_n))));
endmodule

bind wrc_top wrc_checker #(.WBW(WBW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .ret_valid(ret_valid),
  .link_tag (link_tag),
  .win_base (win_base),
  .ret_done (ret_done),
  .illegal  (illegal),
  .uf_code  (uf_code),
  .excm     (excm),
  .old_base (old_base),
  .new_base (new_base)
);

// File: tb/wrc_top_tb_top.sv
`timescale 1ns/1ps
module wrc_top_tb_top;
  localparam int NAREG = 16;
  localparam int NW    = NAREG / 4;
  localparam int WBW   = 2;
  localparam int PC_W  = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ret_valid = 1'b0;
  logic [1:0]      link_tag = '0;
  logic [PC_W-1:0] pc = '0;
  logic            movsp_valid = 1'b0;
  logic [WBW-1:0]  win_base = '0;
  logic [NW-1:0]   win_start = '0;
  logic            ret_done, illegal, excm, alloca;
  logic [1:0]      uf_code;
  logic [WBW-1:0]  old_base, new_base;
  logic [PC_W-1:0] fault_pc;

  int checks = 0;
  int errors = 0;
  logic [WBW-1:0]  exp_ob = '0;
  logic [PC_W-1:0] exp_pc = '0;

  always #4 clk = ~clk;

  wrc_top #(.NAREG(NAREG), .PC_W(PC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .link_tag(link_tag),
    .pc(pc), .movsp_valid(movsp_valid), .win_base(win_base),
    .win_start(win_start), .ret_done(ret_done), .illegal(illegal),
    .uf_code(uf_code), .excm(excm), .old_base(old_base),
    .new_base(new_base), .fault_pc(fault_pc), .alloca(alloca)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ring(input int b, input int k);
    return (b - k + 4 * NW) % NW;
  endfunction

  // Drive one return, compute the expected result independently, compare.
  task automatic do_ret(input string req, input int n, input int b, input int ws, input int p);
    int m = 0;
    bit ill, bitn, uf;
    for (int k = 1; k <= 3; k++)
      if (m == 0 && ws[ring(b, k)]) m = k;
    ill  = (n == 0) || (m != 0 && m != n);
    bitn = (n == 0) ? 1'b1 : ws[ring(b, n)];
    uf   = !ill && !bitn;
    if (uf) begin
      exp_ob = WBW'(b);
      exp_pc = PC_W'(p);
    end
    @(negedge clk);
    ret_valid = 1'b1; link_tag = 2'(n); win_base = WBW'(b);
    win_start = NW'(ws); pc = PC_W'(p);
    @(negedge clk);
    ret_valid = 1'b0;
    check(req, "ret_done", ret_done, 1);
    check(req, "illegal", illegal, ill);
    check(req, "uf_code", uf_code, uf ? n : 0);
    check(req, "excm", excm, uf);
    check(req, "new_base", new_base, ill ? b : ring(b, n));
    check(req, "old_base", old_base, exp_ob);
    check(req, "fault_pc", fault_pc, exp_pc);
  endtask

  task automatic do_movsp(input string req, input int b, input int ws, input bit exp);
    @(negedge clk);
    movsp_valid = 1'b1; win_base = WBW'(b); win_start = NW'(ws);
    @(negedge clk);
    movsp_valid = 1'b0;
    check(req, "alloca", alloca, exp);
    check(req, "no ret_done on movsp", ret_done, 0);
  endtask

  task automatic t_reset;
    check("R10", "reset ret_done", ret_done, 0);
    check("R10", "reset illegal", illegal, 0);
    check("R10", "reset uf_code", uf_code, 0);
    check("R10", "reset new_base", new_base, 0);
    check("R10", "reset alloca", alloca, 0);
  endtask

  task automatic t_zero_size;       // R1: n=0 always illegal
    do_ret("R1", 0, 2, 4'b0010, 32'h100);
    check("R1", "illegal n0", illegal, 1);
  endtask

  task automatic t_search_order;    // R2: base-1 and base-2 both set, first hit wins
    do_ret("R2", 2, 3, 4'b1110, 32'h110);
    check("R2", "m=1 beats n=2", illegal, 1);
    do_ret("R2", 1, 3, 4'b1110, 32'h114);
    check("R2", "m=1 match", illegal, 0);
  endtask

  task automatic t_mismatch;        // R3
    do_ret("R3", 3, 2, 4'b0101, 32'h120);
    check("R3", "m=2 n=3", illegal, 1);
  endtask

  task automatic t_underflow;       // R4: bits below base all clear
    do_ret("R4", 1, 2, 4'b0100, 32'h200);
    check("R4", "uf4 code", uf_code, 1);
    do_ret("R4", 2, 3, 4'b1000, 32'h204);
    check("R4", "uf8 code", uf_code, 2);
    do_ret("R4", 3, 1, 4'b0010, 32'h208);
    check("R4", "uf12 code", uf_code, 3);
  endtask

  task automatic t_normal;          // R5, R6
    do_ret("R5", 2, 2, 4'b0001, 32'h300);
    check("R5", "normal no trap", excm, 0);
    check("R6", "rotated base", new_base, 0);
  endtask

  task automatic t_priority;        // R7: illegal does not touch saved state
    do_ret("R7", 0, 1, 4'b0000, 32'h400);
    check("R7", "base kept", new_base, 1);
    check("R7", "old_base kept", old_base, 1);
  endtask

  task automatic t_wrap;            // R8: base 0 probes top bits
    do_ret("R8", 3, 0, 4'b0010, 32'h500);
    check("R8", "wrap rotate", new_base, 1);
    do_ret("R8", 1, 0, 4'b1001, 32'h504);
    check("R8", "wrap hit bit3", illegal, 0);
  endtask

  task automatic t_alloca;          // R9
    do_movsp("R9", 2, 4'b0100, 1);
    do_movsp("R9", 2, 4'b0110, 1'b1 ^ 1'b1);
    do_movsp("R9", 0, 4'b0010, 0);
    do_movsp("R9", 1, 4'b0010, 1);
  endtask

  task automatic t_idle;            // R10
    @(negedge clk);
    check("R10", "idle ret_done", ret_done, 0);
    check("R10", "idle illegal", illegal, 0);
    check("R10", "idle uf_code", uf_code, 0);
    check("R10", "idle excm", excm, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_zero_size();
        t_search_order();
        t_mismatch();
        t_underflow();
        t_idle();
        t_normal();
        t_priority();
        t_wrap();
        t_alloca();
        t_idle();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule